// File: doc/BRIEF.md
# Fixed-Service DRAM Slot Scheduler

This block sits in a memory controller shared by several security domains and removes the timing channel between them. The data bus is cut into slots of a fixed number of cycles. The slots are handed to the domains in strict rotation, whatever the load. Each domain writes read and write requests into its own queue. When a slot comes up for commitment, the scheduler takes the head request of the owning domain. If that queue is empty, it makes up a dummy read instead. The scheduler then places the activate and the column command on the shared command bus, working backward from the slot boundary so that the data burst starts exactly on it.

Commands are put into a short delay line when the slot is committed. A read needs more lead time than a write, so the command offsets depend on the access type. If a new command would land on a command-bus cycle that is already taken, the command that was scheduled first is kept, the new one is dropped, and a sticky configuration-error flag is raised. A completion pulse goes back to the owning domain a fixed number of cycles after its slot boundary, and only for real accesses.

An optional triple-alternation mode tags every slot with a bank group that rotates through three values. This lets the slot length drop below the same-bank recovery gap.

Top module: `fss_slot_sched`

## Requirements
- R1: Reset state. Cycle n counts the rising edges since reset was released, and the reset state is the state at n = 0. At n = 0 `cmd_op` is NOP, `done_o` is 0, `cfg_err` is 0 and every `req_ready` bit is 1.
- R2: Slot k (k = 0, 1, 2, ...) belongs to domain k mod NUM_DOM. Slot k is committed in cycle n = k·SLOT_LEN, and its commands are timed from base B = 1 + k·SLOT_LEN. With LEAD = max(T_CAS, T_CWD) + T_RCD, the data boundary of slot k is at B + LEAD.
- R3: A read in slot k puts ACT on the bus at B + LEAD − (T_CAS + T_RCD) and RD at B + LEAD − T_CAS. With the default timings these are B + 0 and B + 11.
- R4: A write in slot k puts ACT at B + LEAD − (T_CWD + T_RCD) and WR at B + LEAD − T_CWD. With the default timings these are B + 6 and B + 17.
- R5: If the owning domain's queue is empty when its slot is committed, a dummy read to bank 0, row 0 is issued with the read timing of R3.
- R6: `cmd_op` encodes NOP = 0, ACT = 1, RD = 2 and WR = 3. `cmd_bank` is valid on ACT and on both column commands. `cmd_row` carries the row on ACT and is 0 on RD and WR.
- R7: Each domain has a first-in first-out queue of QDEPTH entries. A request is taken at a rising edge when `req_valid` and `req_ready` are both 1. `req_ready` is 0 exactly while the queue is full. Requests are served in arrival order.
- R8: A request leaves its queue only at the commit of a slot of its domain. A request taken at the same edge as that commit is not served in that slot. It waits for the domain's slot in the next quantum.
- R9: A real access in slot k pulses `done_o[k mod NUM_DOM]` for exactly one cycle, at n = B + LEAD + T_DONE. A dummy access produces no pulse.
- R10: With ALT_MODE = 1, `cmd_grp` on the ACT and on the column command of slot k equals k mod 3. With ALT_MODE = 0, `cmd_grp` is always 0.
- R11: When a command would land on a command-bus cycle that an earlier slot already occupies, the earlier command stays on the bus and the new one is dropped. `cfg_err` becomes 1 at n = B of the committing slot and stays 1 until reset. A configuration without collisions never raises `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_DOM | Request offered, one bit per domain |
| req_write | input | NUM_DOM | 1 = write, 0 = read, one bit per domain |
| req_bank | input | NUM_DOM×BANK_W | Bank of each domain's request |
| req_row | input | NUM_DOM×ROW_W | Row of each domain's request |
| req_ready | output | NUM_DOM | Queue of that domain can accept a request |
| cmd_op | output | 2 | Command bus operation (NOP/ACT/RD/WR) |
| cmd_bank | output | BANK_W | Command bus bank |
| cmd_grp | output | 2 | Bank group tag of the command |
| cmd_row | output | ROW_W | Row, valid on ACT |
| done_o | output | NUM_DOM | Completion pulse for each domain |
| cfg_err | output | 1 | Sticky command-bus collision flag |

## Verification
The assertions assume a slot length of at least two cycles. They also assume timing parameters that give offsets inside the lead window. A request is only taken when the queue shows ready, and the queue assertions depend on that: the top never pops an empty queue and never pushes a full one.

The stimulus stays within these assumptions. It offers requests only at sampling points where the queue has room. It drives inputs half a cycle away from the sampling edge. It places each push a known number of cycles before or exactly at a commit edge, so that the slot serving each request is known in advance. The collision case uses a separate instance with a six-cycle slot, where a write followed by a read must collide.

// File: rtl/fss_pkg.sv
// Shared types of the fixed-service slot scheduler.
package fss_pkg;
    // Command bus operation codes
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } cmd_op_e;
endpackage

// File: rtl/fss_req_fifo.sv
// Per-domain request queue: first-in first-out, DEPTH entries of WIDTH bits.
// Assumes the caller pushes only when not full and pops only when not empty.
module fss_req_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write
    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr] <= data_i;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_i)  rd_ptr <= ptr_inc(rd_ptr);
            case ({push_i, pop_i})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_o  = mem[rd_ptr];
    assign full_o  = (count == CNT_W'(DEPTH));
    assign empty_o = (count == '0);

    // R8
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
    // R7
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
endmodule

// File: rtl/fss_slot_timer.sv
// Slot timer: raises commit for one cycle every SLOT_LEN cycles, starting
// right after reset. Tells which domain owns the slot being committed and
// keeps a modulo-3 slot tag for bank-group rotation. Assumes SLOT_LEN >= 2.
module fss_slot_timer #(
    parameter int SLOT_LEN = 15,
    parameter int NUM_DOM  = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    output logic                                    commit_o,
    output logic [((NUM_DOM > 1) ? $clog2(NUM_DOM) : 1)-1:0] owner_o,
    output logic [1:0]                              grp_o
);
    localparam int CNT_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
    localparam int DOM_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;

    logic [CNT_W-1:0] cnt;
    logic [DOM_W-1:0] owner;
    logic [1:0]       grp;

    // Cycle-in-slot counter, owner rotation and group rotation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            owner <= '0;
            grp   <= '0;
        end else begin
            cnt <= (cnt == CNT_W'(SLOT_LEN - 1)) ? '0 : cnt + 1'b1;
            if (commit_o) begin
                owner <= (owner == DOM_W'(NUM_DOM - 1)) ? '0 : owner + 1'b1;
                grp   <= (grp == 2'd2) ? 2'd0 : grp + 2'd1;
            end
        end
    end

    assign commit_o = (cnt == '0);
    assign owner_o  = owner;
    assign grp_o    = grp;

    // R10
    grp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_o != 2'd3);
    // R2
    owner_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner_o <= DOM_W'(NUM_DOM - 1));
endmodule

// File: rtl/fss_cmd_pipe.sv
// Command delay line: at each commit it places an ACT and a column command
// at offsets counted back from the slot's data boundary. Position p is on the
// bus p cycles after the commit edge. A cycle that is already taken keeps its
// first command, and the collision sets a sticky error.
// Assumes T_RCD >= 1, so the two commands of one slot never share a cycle.
module fss_cmd_pipe
    import fss_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 8,
    parameter int T_CAS  = 11,
    parameter int T_CWD  = 5,
    parameter int T_RCD  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic              is_wr_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [1:0]        grp_i,
    output logic [1:0]        cmd_op_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [1:0]        cmd_grp_o,
    output logic [ROW_W-1:0]  cmd_row_o,
    output logic              cfg_err_o
);
    localparam int LEAD   = ((T_CAS > T_CWD) ? T_CAS : T_CWD) + T_RCD;
    localparam int DEPTH  = LEAD;
    localparam int RD_ACT = LEAD - (T_CAS + T_RCD);
    localparam int RD_CAS = LEAD - T_CAS;
    localparam int WR_ACT = LEAD - (T_CWD + T_RCD);
    localparam int WR_CAS = LEAD - T_CWD;

    typedef struct packed {
        cmd_op_e           op;
        logic [BANK_W-1:0] bank;
        logic [1:0]        grp;
        logic [ROW_W-1:0]  row;
    } cmd_ent_t;

    cmd_ent_t ent [DEPTH];
    cmd_ent_t shf [DEPTH];
    cmd_ent_t nxt [DEPTH];
    logic     hit;
    logic     err_q;

    // Advance the line by one cycle
    genvar p;
    generate
        for (p = 0; p < DEPTH - 1; p++) begin : g_shift
            assign shf[p] = ent[p+1];
        end
    endgenerate
    assign shf[DEPTH-1] = '0;

    // Place the new slot's commands and detect occupied cycles
    always_comb begin
        int a_off;
        int c_off;
        cmd_ent_t a_ent;
        cmd_ent_t c_ent;
        nxt   = shf;
        hit   = 1'b0;
        a_off = is_wr_i ? WR_ACT : RD_ACT;
        c_off = is_wr_i ? WR_CAS : RD_CAS;
        a_ent = '{op: CMD_ACT, bank: bank_i, grp: grp_i, row: row_i};
        c_ent = '{op: (is_wr_i ? CMD_WR : CMD_RD), bank: bank_i, grp: grp_i, row: '0};
        if (commit_i) begin
            if (nxt[a_off].op != CMD_NOP) hit = 1'b1;
            else                          nxt[a_off] = a_ent;
            if (nxt[c_off].op != CMD_NOP) hit = 1'b1;
            else                          nxt[c_off] = c_ent;
        end
    end

    // Line registers and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
            err_q <= 1'b0;
        end else begin
            ent <= nxt;
            if (hit) err_q <= 1'b1;
        end
    end

    assign cmd_op_o   = ent[0].op;
    assign cmd_bank_o = ent[0].bank;
    assign cmd_grp_o  = ent[0].grp;
    assign cmd_row_o  = ent[0].row;
    assign cfg_err_o  = err_q;

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o);
    // R6
    cas_row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op_o == CMD_RD || cmd_op_o == CMD_WR) |-> cmd_row_o == '0);
endmodule

// File: rtl/fss_done_pipe.sv
// Completion delay: a real access committed at an edge raises the owner's
// done bit exactly LAT cycles after that edge, for one cycle.
// Assumes LAT >= 1 and that commits are at least two cycles apart.
module fss_done_pipe #(
    parameter int LAT     = 26,
    parameter int NUM_DOM = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    commit_i,
    input  logic                                    real_i,
    input  logic [((NUM_DOM > 1) ? $clog2(NUM_DOM) : 1)-1:0] dom_i,
    output logic [NUM_DOM-1:0]                      done_o
);
    localparam int DOM_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;

    logic             vld [LAT+1];
    logic [DOM_W-1:0] dm  [LAT+1];

    // Shift completions toward the output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= LAT; i++) begin
                vld[i] <= 1'b0;
                dm[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < LAT; i++) begin
                vld[i] <= vld[i+1];
                dm[i]  <= dm[i+1];
            end
            vld[LAT] <= commit_i & real_i;
            dm[LAT]  <= dom_i;
        end
    end

    // Decode the output entry to one bit per domain
    genvar d;
    generate
        for (d = 0; d < NUM_DOM; d++) begin : g_done
            assign done_o[d] = vld[0] && (dm[0] == DOM_W'(d));
        end
    endgenerate

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_o) |=> ((done_o & $past(done_o)) == '0));
endmodule

// File: rtl/fss_slot_sched.sv
// Fixed-service slot scheduler top. Each domain queues requests. Every
// SLOT_LEN cycles the timer commits the next slot in round-robin order. The
// owner's head request, or a dummy read to bank 0/row 0 when its queue is
// empty, goes into the command delay line, and a completion is scheduled.
// Assumes SLOT_LEN >= 2 and the default parameter relations of the brief.
module fss_slot_sched
    import fss_pkg::*;
#(
    parameter int NUM_DOM  = 4,
    parameter int SLOT_LEN = 15,
    parameter int QDEPTH   = 4,
    parameter int BANK_W   = 3,
    parameter int ROW_W    = 8,
    parameter int T_CAS    = 11,
    parameter int T_CWD    = 5,
    parameter int T_RCD    = 11,
    parameter int T_DONE   = 4,
    parameter bit ALT_MODE = 1'b0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_DOM-1:0]              req_valid,
    input  logic [NUM_DOM-1:0]              req_write,
    input  logic [NUM_DOM-1:0][BANK_W-1:0]  req_bank,
    input  logic [NUM_DOM-1:0][ROW_W-1:0]   req_row,
    output logic [NUM_DOM-1:0]              req_ready,
    output logic [1:0]                      cmd_op,
    output logic [BANK_W-1:0]               cmd_bank,
    output logic [1:0]                      cmd_grp,
    output logic [ROW_W-1:0]                cmd_row,
    output logic [NUM_DOM-1:0]              done_o,
    output logic                            cfg_err
);
    localparam int DOM_W    = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
    localparam int REQ_W    = 1 + BANK_W + ROW_W;
    localparam int LEAD     = ((T_CAS > T_CWD) ? T_CAS : T_CWD) + T_RCD;
    localparam int DONE_LAT = LEAD + T_DONE;

    logic                          commit;
    logic [DOM_W-1:0]              owner;
    logic [1:0]                    slot_grp;
    logic [1:0]                    grp_sel;
    logic [NUM_DOM-1:0]            q_full, q_empty, q_push, q_pop;
    logic [NUM_DOM-1:0][REQ_W-1:0] q_head;
    logic [REQ_W-1:0]              sel_head;
    logic                          sel_real;
    logic                          sel_wr;
    logic [BANK_W-1:0]             sel_bank;
    logic [ROW_W-1:0]              sel_row;

    fss_slot_timer #(.SLOT_LEN(SLOT_LEN), .NUM_DOM(NUM_DOM)) u_timer (
        .clk(clk), .rst_n(rst_n), .commit_o(commit), .owner_o(owner), .grp_o(slot_grp)
    );

    // One queue per domain
    genvar d;
    generate
        for (d = 0; d < NUM_DOM; d++) begin : g_dom
            assign q_push[d]    = req_valid[d] & ~q_full[d];
            assign q_pop[d]     = commit & (owner == DOM_W'(d)) & ~q_empty[d];
            assign req_ready[d] = ~q_full[d];
            fss_req_fifo #(.DEPTH(QDEPTH), .WIDTH(REQ_W)) u_q (
                .clk(clk), .rst_n(rst_n),
                .push_i(q_push[d]),
                .data_i({req_write[d], req_bank[d], req_row[d]}),
                .pop_i(q_pop[d]),
                .head_o(q_head[d]),
                .full_o(q_full[d]),
                .empty_o(q_empty[d])
            );
        end
    endgenerate

    // Pick the owner's head request or a dummy read
    always_comb begin
        sel_head = q_head[owner];
        sel_real = ~q_empty[owner];
        sel_wr   = sel_real & sel_head[REQ_W-1];
        sel_bank = sel_real ? sel_head[ROW_W +: BANK_W] : '0;
        sel_row  = sel_real ? sel_head[ROW_W-1:0] : '0;
    end

    // Bank-group tag depends on the rotation mode
    generate
        if (ALT_MODE) begin : g_alt
            assign grp_sel = slot_grp;
        end else begin : g_plain
            assign grp_sel = 2'd0;
        end
    endgenerate

    fss_cmd_pipe #(
        .BANK_W(BANK_W), .ROW_W(ROW_W),
        .T_CAS(T_CAS), .T_CWD(T_CWD), .T_RCD(T_RCD)
    ) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .commit_i(commit), .is_wr_i(sel_wr), .bank_i(sel_bank),
        .row_i(sel_row), .grp_i(grp_sel),
        .cmd_op_o(cmd_op), .cmd_bank_o(cmd_bank), .cmd_grp_o(cmd_grp),
        .cmd_row_o(cmd_row), .cfg_err_o(cfg_err)
    );

    fss_done_pipe #(.LAT(DONE_LAT), .NUM_DOM(NUM_DOM)) u_done (
        .clk(clk), .rst_n(rst_n),
        .commit_i(commit), .real_i(sel_real), .dom_i(owner), .done_o(done_o)
    );

    // Independent gap counter between commits, used only by the check below
    logic [15:0] gap_cnt;
    logic        gap_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt  <= '0;
            gap_seen <= 1'b0;
        end else if (commit) begin
            gap_cnt  <= '0;
            gap_seen <= 1'b1;
        end else begin
            gap_cnt <= gap_cnt + 16'd1;
        end
    end

    // R2
    slot_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (!gap_seen || gap_cnt == 16'(SLOT_LEN - 1)));
endmodule

// File: tb/fss_slot_sched_tb.sv
`timescale 1ns/1ps
module fss_slot_sched_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) if (rst_n) n <= n + 1;

    // Main instance: 4 domains, 15-cycle slot, triple alternation
    logic [3:0]       d_valid = '0, d_write = '0, d_ready;
    logic [3:0][2:0]  d_bank = '0;
    logic [3:0][7:0]  d_row = '0;
    logic [1:0]       d_op, d_grp;
    logic [2:0]       d_cbank;
    logic [7:0]       d_crow;
    logic [3:0]       d_done;
    logic             d_err;

    fss_slot_sched #(.NUM_DOM(4), .SLOT_LEN(15), .QDEPTH(4), .BANK_W(3), .ROW_W(8),
                     .T_CAS(11), .T_CWD(5), .T_RCD(11), .T_DONE(4), .ALT_MODE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(d_valid), .req_write(d_write),
        .req_bank(d_bank), .req_row(d_row), .req_ready(d_ready),
        .cmd_op(d_op), .cmd_bank(d_cbank), .cmd_grp(d_grp), .cmd_row(d_crow),
        .done_o(d_done), .cfg_err(d_err)
    );

    // Collision instance: 2 domains, 6-cycle slot, plain rotation
    logic [1:0]       b_valid = '0, b_write = '0, b_ready;
    logic [1:0][2:0]  b_bank = '0;
    logic [1:0][7:0]  b_row = '0;
    logic [1:0]       b_op, b_grp;
    logic [2:0]       b_cbank;
    logic [7:0]       b_crow;
    logic [1:0]       b_done;
    logic             b_err;

    fss_slot_sched #(.NUM_DOM(2), .SLOT_LEN(6), .QDEPTH(4), .BANK_W(3), .ROW_W(8),
                     .T_CAS(11), .T_CWD(5), .T_RCD(11), .T_DONE(4), .ALT_MODE(1'b0)) u_bad (
        .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_write(b_write),
        .req_bank(b_bank), .req_row(b_row), .req_ready(b_ready),
        .cmd_op(b_op), .cmd_bank(b_cbank), .cmd_grp(b_grp), .cmd_row(b_crow),
        .done_o(b_done), .cfg_err(b_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (n=%0d)", tag, act, exp, n);
        end
    endtask

    task automatic wait_n(input int t);
        while (n < t) @(negedge clk);
    endtask

    // Check ACT fields of the main instance at cycle t
    task automatic chk_act(input string tag, input int t, input int bank, input int row, input int grp);
        wait_n(t);
        chk({tag, " op"},   int'(d_op), 1);
        chk({tag, " bank"}, int'(d_cbank), bank);
        chk({tag, " row"},  int'(d_crow), row);
        chk({tag, " grp"},  int'(d_grp), grp);
    endtask

    // Check a column command of the main instance at cycle t
    task automatic chk_cas(input string tag, input int t, input int op, input int bank, input int grp);
        wait_n(t);
        chk({tag, " op"},   int'(d_op), op);
        chk({tag, " bank"}, int'(d_cbank), bank);
        chk({tag, " row"},  int'(d_crow), 0);
        chk({tag, " grp"},  int'(d_grp), grp);
    endtask

    // R1: reset state
    task automatic t_reset();
        chk("R1 cmd_op", int'(d_op), 0);
        chk("R1 done", int'(d_done), 0);
        chk("R1 cfg_err", int'(d_err), 0);
        chk("R1 ready", int'(d_ready), 4'hF);
    endtask

    // Stimulus for the main instance
    task automatic drive_dut();
        wait_n(2);
        d_valid = 4'b1110;
        d_write = 4'b0100;
        d_bank[1] = 3'd5; d_row[1] = 8'h3C;
        d_bank[2] = 3'd2; d_row[2] = 8'h11;
        d_bank[3] = 3'd1; d_row[3] = 8'h07;
        @(negedge clk);
        d_valid = 4'b1000; d_write = 4'b0000;
        d_bank[3] = 3'd4; d_row[3] = 8'h09;
        @(negedge clk);
        d_valid = '0;
        wait_n(135);                       // same edge as slot 9 commit
        d_valid = 4'b0010; d_bank[1] = 3'd6; d_row[1] = 8'h55;
        @(negedge clk);
        d_valid = '0;
        wait_n(141);                       // fill domain 2's queue
        d_valid = 4'b0100; d_write = 4'b0100;
        repeat (4) @(negedge clk);
        d_valid = '0; d_write = '0;
    endtask

    // R5 R2 R9: dummy slots of domain 0
    task automatic t_dummy();
        chk_act("R5 dummy slot0 ACT", 1, 0, 0, 0);
        chk_cas("R5 dummy slot0 RD", 12, 2, 0, 0);
        wait_n(27);
        chk("R9 no done for dummy slot0", int'(d_done[0]), 0);
        chk_act("R5 dummy slot4 ACT", 61, 0, 0, 1);
        wait_n(87);
        chk("R9 no done for dummy slot4", int'(d_done), 0);
    endtask

    // R3 R4 R6 R7 R9 R10: real reads and writes
    task automatic t_real();
        chk_act("R3 R10 slot1 read ACT", 16, 5, 8'h3C, 1);
        chk_cas("R3 R6 slot1 RD", 27, 2, 5, 1);
        chk_act("R4 R10 slot2 write ACT", 37, 2, 8'h11, 2);
        wait_n(41);
        chk("R9 before done", int'(d_done), 0);
        @(negedge clk);
        chk("R9 done dom1", int'(d_done), 4'b0010);
        @(negedge clk);
        chk("R9 after done", int'(d_done), 0);
        chk_act("R3 R10 slot3 read ACT", 46, 1, 8'h07, 0);
        chk_cas("R4 R6 slot2 WR", 48, 3, 2, 2);
        chk_cas("R3 slot3 RD", 57, 2, 1, 0);
        chk("R9 done dom2 write", int'(d_done), 4'b0100);
        wait_n(72);
        chk("R9 done dom3", int'(d_done), 4'b1000);
        chk_act("R7 second queued entry slot7", 106, 4, 8'h09, 1);
        wait_n(132);
        chk("R9 done dom3 second", int'(d_done), 4'b1000);
    endtask

    // R8: request arriving at the commit edge waits a quantum
    task automatic t_commit();
        chk_act("R8 slot9 still dummy", 136, 0, 0, 0);
        chk_act("R8 R10 served in slot13", 196, 6, 8'h55, 1);
    endtask

    // R7: queue full and freed by a commit
    task automatic t_full();
        wait_n(145);
        chk("R7 ready low when full", int'(d_ready[2]), 0);
        wait_n(150);
        chk("R7 ready still low", int'(d_ready[2]), 0);
        @(negedge clk);
        chk("R7 ready after pop", int'(d_ready[2]), 1);
        wait_n(260);
        chk("R11 no error on clean timing", int'(d_err), 0);
    endtask

    // R11 R10: collision on the 6-cycle instance
    task automatic t_collide();
        wait_n(2);
        b_valid = 2'b01; b_write = 2'b01; b_bank[0] = 3'd3; b_row[0] = 8'h21;
        @(negedge clk);
        b_valid = '0; b_write = '0;
        wait_n(8);
        b_valid = 2'b10; b_bank[1] = 3'd6; b_row[1] = 8'h44;
        @(negedge clk);
        b_valid = '0;
        wait_n(18);
        chk("R11 no error before collision", int'(b_err), 0);
        @(negedge clk);
        chk("R11 error raised", int'(b_err), 1);
        chk("R11 first ACT kept op", int'(b_op), 1);
        chk("R11 first ACT kept bank", int'(b_cbank), 3);
        chk("R11 first ACT kept row", int'(b_crow), 8'h21);
        chk("R10 plain mode grp", int'(b_grp), 0);
        wait_n(30);
        chk("R11 first WR kept op", int'(b_op), 3);
        chk("R11 first WR kept bank", int'(b_cbank), 3);
        chk("R11 error sticky", int'(b_err), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        fork
            drive_dut();
            t_dummy();
            t_real();
            t_commit();
            t_full();
            t_collide();
        join
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n, 300);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule